// File: doc/BRIEF.md
# Frame-Sync Monitor and Clock-Rate Detector

This block sits between the frame-sync pin and the serial data port of a two-channel voice codec. It counts bit-clock cycles between successive rising edges of frame sync. From that count it works out whether the bit clock runs at the low rate (nominally 256 clocks per 125 µs frame, 2.048 MHz) or the high rate (nominally 512 clocks per frame, 4.096 MHz). Once two consecutive frame periods agree on one rate, it latches that rate and holds it. No control register is involved.

The same cycle count also serves as an idle timer. If frame sync stays low long enough, the block raises one shared powerdown output for both voice channels. The timeout is 1024 clocks when locked to the low rate and 2048 clocks otherwise, which is about 500 µs either way. The next frame-sync rising edge wakes the block, and the rate is then measured again from scratch. Each rising edge seen while awake produces a one-cycle strobe that marks the start of a frame for the serial port.

Frame sync is sampled on the falling edge of the bit clock, the same edge the receive data uses. A rising edge is a high sample that follows a low sample, so a pulse of any width of at least one clock counts once.

Top module: `fsync_rate_monitor`

## Requirements
- R1: While and directly after synchronous reset, `rate_valid`, `rate_high`, `power_down` and `frame_strobe` are all 0.
- R2: `fs_in` is sampled on the falling clock edge. A rising edge is a high sample following a low sample, and a pulse of any width of at least one clock yields exactly one rising edge.
- R3: `frame_strobe` is high for exactly one clock, on the rising clock edge where a rising edge of frame sync is detected. It is never high while `power_down` is high, and the edge that wakes the block gives no strobe.
- R4: A measured period (clocks between two detected rising edges) within ±TOL of NOM_LO classifies as low rate, within ±TOL of NOM_HI as high rate, and any other count as unclassified.
- R5: `rate_valid` rises only at a rising edge whose period has the same class as the period just before it. The two periods must be consecutive and classified, and no unclassified period may lie between them. At that edge, `rate_high` takes the value 1 for the high rate and 0 for the low rate.
- R6: Once `rate_valid` is high, `rate_high` and `rate_valid` keep their values whatever the later frame periods are, until powerdown or reset.
- R7: `power_down` rises exactly TIMEOUT clocks after the last detected rising edge. TIMEOUT is TO_LO when locked to the low rate and TO_HI in every other case. `rate_valid` clears on the same clock.
- R8: A rising edge detected while `power_down` is high clears `power_down` on that clock and starts a new measurement. `rate_high` keeps its old value until a new lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| fs_in | input | 1 | Frame-sync input |
| rate_high | output | 1 | Locked rate: 1 high, 0 low |
| rate_valid | output | 1 | Rate has been locked |
| power_down | output | 1 | Shared low-power request for both channels |
| frame_strobe | output | 1 | One-clock marker of a detected frame start |

## Verification
The bench builds the block with NOM_LO=32, NOM_HI=64, TOL=2, TO_LO=128 and TO_HI=256. These values keep the same 1:2 rate ratio and the same 4:1 timeout-to-frame ratio as the defaults. With them, both timeout boundaries are checked clock by clock, at one cycle before expiry and at expiry. The same run covers tolerance edges one count inside and one count outside the band, a rate mismatch before lock, and a full sleep-wake-relock cycle at the other rate.

// File: rtl/fsrm_pkg.sv
`timescale 1ns/1ps
package fsrm_pkg;

    typedef enum logic [1:0] {
        RC_NONE = 2'd0,
        RC_LOW  = 2'd1,
        RC_HIGH = 2'd2
    } rate_class_e;

    typedef enum logic [1:0] {
        LK_ARM     = 2'd0,  // waiting for a first edge
        LK_FIRST   = 2'd1,  // timing the first period
        LK_CONFIRM = 2'd2,  // one class stored, waiting for agreement
        LK_HELD    = 2'd3   // rate latched
    } lock_state_e;

    typedef struct packed {
        logic valid;
        logic high;
    } rate_info_t;

    function automatic rate_class_e classify(
        input int unsigned count,
        input int unsigned nom_lo,
        input int unsigned nom_hi,
        input int unsigned tol
    );
        if ((count + tol >= nom_lo) && (count <= nom_lo + tol))
            return RC_LOW;
        if ((count + tol >= nom_hi) && (count <= nom_hi + tol))
            return RC_HIGH;
        return RC_NONE;
    endfunction

    function automatic int unsigned span_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fsrm_edge.sv
`timescale 1ns/1ps
module fsrm_edge #(
    parameter bit SAMPLE_FALLING = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic fs_in,
    output logic rise
);
    logic samp;
    logic prev;

    generate
        if (SAMPLE_FALLING) begin : g_neg
            always_ff @(negedge clk) begin
                if (rst) samp <= 1'b0;
                else     samp <= fs_in;
            end
        end else begin : g_pos
            always_ff @(posedge clk) begin
                if (rst) samp <= 1'b0;
                else     samp <= fs_in;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= samp;
    end

    assign rise = samp & ~prev;

    // a detected edge cannot repeat on the next rising clock edge
    assert_rise_once_R2: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

endmodule

// File: rtl/fsrm_period.sv
`timescale 1ns/1ps
module fsrm_period #(
    parameter int unsigned CW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rise,
    output logic [CW-1:0] count
);
    localparam logic [CW-1:0] CNT_TOP = {CW{1'b1}};

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (rise)
            count <= CW'(1);
        else if (count != CNT_TOP)
            count <= count + CW'(1);
    end

    assert_count_restart_R4: assert property (@(posedge clk) disable iff (rst)
        rise |=> (count == CW'(1)));

endmodule

// File: rtl/fsrm_lock.sv
`timescale 1ns/1ps
module fsrm_lock
    import fsrm_pkg::*;
#(
    parameter int unsigned NOM_LO = 256,
    parameter int unsigned NOM_HI = 512,
    parameter int unsigned TOL    = 4,
    parameter int unsigned CW     = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rise,
    input  logic          timeout_hit,
    input  logic [CW-1:0] count,
    output rate_info_t    info
);
    lock_state_e st;
    rate_class_e held;
    rate_class_e cls;

    assign cls = classify(32'(count), NOM_LO, NOM_HI, TOL);

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= LK_ARM;
            held       <= RC_NONE;
            info.valid <= 1'b0;
            info.high  <= 1'b0;
        end else if (timeout_hit) begin
            st         <= LK_ARM;
            info.valid <= 1'b0;
        end else if (rise) begin
            unique case (st)
                LK_ARM: st <= LK_FIRST;
                LK_FIRST: begin
                    if (cls != RC_NONE) begin
                        held <= cls;
                        st   <= LK_CONFIRM;
                    end
                end
                LK_CONFIRM: begin
                    if (cls == RC_NONE) begin
                        st <= LK_FIRST;
                    end else if (cls == held) begin
                        st         <= LK_HELD;
                        info.valid <= 1'b1;
                        info.high  <= (cls == RC_HIGH);
                    end else begin
                        held <= cls;
                    end
                end
                default: ;
            endcase
        end
    end

    assert_lock_hold_R6: assert property (@(posedge clk) disable iff (rst)
        ($past(info.valid) && info.valid) |-> (info.high == $past(info.high)));

    assert_lock_on_edge_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(info.valid) |-> $past(rise));

endmodule

// File: rtl/fsrm_sleep.sv
`timescale 1ns/1ps
module fsrm_sleep
    import fsrm_pkg::*;
#(
    parameter int unsigned TO_LO = 1024,
    parameter int unsigned TO_HI = 2048,
    parameter int unsigned CW    = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rise,
    input  logic [CW-1:0] count,
    input  rate_info_t    info,
    output logic          timeout_hit,
    output logic          power_down
);
    logic [CW-1:0] limit;

    assign limit       = (info.valid && !info.high) ? CW'(TO_LO) : CW'(TO_HI);
    assign timeout_hit = !power_down && !rise && (count >= limit);

    always_ff @(posedge clk) begin
        if (rst)              power_down <= 1'b0;
        else if (rise)        power_down <= 1'b0;
        else if (timeout_hit) power_down <= 1'b1;
    end

    assert_wake_R8: assert property (@(posedge clk) disable iff (rst)
        (power_down && rise) |=> !power_down);

    assert_sleep_unlocked_R7: assert property (@(posedge clk) disable iff (rst)
        power_down |-> !info.valid);

endmodule

// File: rtl/fsync_rate_monitor.sv
`timescale 1ns/1ps
module fsync_rate_monitor
    import fsrm_pkg::*;
#(
    parameter int unsigned NOM_LO         = 256,
    parameter int unsigned NOM_HI         = 512,
    parameter int unsigned TOL            = 4,
    parameter int unsigned TO_LO          = 1024,
    parameter int unsigned TO_HI          = 2048,
    parameter bit          SAMPLE_FALLING = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic fs_in,
    output logic rate_high,
    output logic rate_valid,
    output logic power_down,
    output logic frame_strobe
);
    localparam int unsigned SPAN = span_max(span_max(TO_LO, TO_HI), NOM_HI + TOL);
    localparam int unsigned CW   = $clog2(SPAN + 2);

    logic          rise;
    logic [CW-1:0] count;
    logic          timeout_hit;
    rate_info_t    info;

    fsrm_edge #(.SAMPLE_FALLING(SAMPLE_FALLING)) u_edge (
        .clk   (clk),
        .rst   (rst),
        .fs_in (fs_in),
        .rise  (rise)
    );

    fsrm_period #(.CW(CW)) u_period (
        .clk   (clk),
        .rst   (rst),
        .rise  (rise),
        .count (count)
    );

    fsrm_lock #(.NOM_LO(NOM_LO), .NOM_HI(NOM_HI), .TOL(TOL), .CW(CW)) u_lock (
        .clk         (clk),
        .rst         (rst),
        .rise        (rise),
        .timeout_hit (timeout_hit),
        .count       (count),
        .info        (info)
    );

    fsrm_sleep #(.TO_LO(TO_LO), .TO_HI(TO_HI), .CW(CW)) u_sleep (
        .clk         (clk),
        .rst         (rst),
        .rise        (rise),
        .count       (count),
        .info        (info),
        .timeout_hit (timeout_hit),
        .power_down  (power_down)
    );

    always_ff @(posedge clk) begin
        if (rst) frame_strobe <= 1'b0;
        else     frame_strobe <= rise && !power_down;
    end

    assign rate_high  = info.high;
    assign rate_valid = info.valid;

    assert_strobe_single_R3: assert property (@(posedge clk) disable iff (rst)
        frame_strobe |=> !frame_strobe);

    assert_strobe_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        power_down |-> !frame_strobe);

endmodule

// File: tb/test_fsync_rate_monitor.sv
`timescale 1ns/1ps
module test_fsync_rate_monitor;

    localparam int unsigned LO  = 32;
    localparam int unsigned HI  = 64;
    localparam int unsigned TOL = 2;
    localparam int unsigned TLO = 128;
    localparam int unsigned THI = 256;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic fs  = 1'b0;
    logic rate_high, rate_valid, power_down, frame_strobe;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        logic  s;
        logic  v;
        logic  h;
        logic  p;
        string req;
    } exp_t;

    exp_t q[$];

    always #10 clk = ~clk;

    fsync_rate_monitor #(
        .NOM_LO(LO), .NOM_HI(HI), .TOL(TOL), .TO_LO(TLO), .TO_HI(THI), .SAMPLE_FALLING(1'b1)
    ) i_fsync_rate_monitor (
        .clk          (clk),
        .rst          (rst),
        .fs_in        (fs),
        .rate_high    (rate_high),
        .rate_valid   (rate_valid),
        .power_down   (power_down),
        .frame_strobe (frame_strobe)
    );

    // monitor: compare one expected item per falling edge
    always @(negedge clk) begin
        if (q.size() != 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if ({frame_strobe, rate_valid, rate_high, power_down} !== {e.s, e.v, e.h, e.p}) begin
                errors++;
                $display("FAIL %s strobe/valid/high/pd got %b%b%b%b expected %b%b%b%b",
                         e.req, frame_strobe, rate_valid, rate_high, power_down,
                         e.s, e.v, e.h, e.p);
            end
        end
    end

    task automatic push(input logic s, input logic v, input logic h, input logic p, input string req);
        exp_t e;
        e.s = s; e.v = v; e.h = h; e.p = p; e.req = req;
        q.push_back(e);
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // one frame: pulse of w clocks, next rising edge p clocks later
    task automatic frame(input int p, input int w, input logic s, input logic v,
                         input logic h, input logic pd, input string req);
        @(posedge clk); #1 fs = 1'b1;
        @(posedge clk); #1;
        push(s, v, h, pd, req);
        if (w == 1) fs = 1'b0;
        for (int k = 1; k <= p - 2; k++) begin
            @(posedge clk); #1;
            if (k == w - 1) fs = 1'b0;
            if (k == 1) push(1'b0, v, h, pd, req);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired, got running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(4);
        rst = 1'b0;
        push(1'b0, 1'b0, 1'b0, 1'b0, "R1 reset state");
        idle(2);

        // first edge, then a period sequence lo, hi, lo, lo
        frame(LO,     1, 1'b1, 1'b0, 1'b0, 1'b0, "R2 first edge strobes");
        frame(HI,     3, 1'b1, 1'b0, 1'b0, 1'b0, "R4 low class stored, R2 wide pulse");
        frame(LO+1,   5, 1'b1, 1'b0, 1'b0, 1'b0, "R5 mismatch high vs low no lock");
        frame(LO-1,   1, 1'b1, 1'b0, 1'b0, 1'b0, "R5 mismatch low vs high no lock");
        frame(HI,     2, 1'b1, 1'b1, 1'b0, 1'b0, "R5 two low periods lock low");
        frame(3,      1, 1'b1, 1'b1, 1'b0, 1'b0, "R6 high period after lock ignored");

        // low-rate timeout
        idle(TLO - 2);
        push(1'b0, 1'b1, 1'b0, 1'b0, "R7 one clock before low timeout");
        idle(1);
        push(1'b0, 1'b0, 1'b0, 1'b1, "R7 low timeout reached");
        idle(50);
        push(1'b0, 1'b0, 1'b0, 1'b1, "R3 no strobe while asleep");

        // wake and relock at the high rate, tolerance edges
        frame(HI+TOL+1, 1, 1'b0, 1'b0, 1'b0, 1'b0, "R8 wake clears pd, R3 no wake strobe");
        frame(HI+TOL,   2, 1'b1, 1'b0, 1'b0, 1'b0, "R4 out of band unclassified");
        frame(HI-TOL,   1, 1'b1, 1'b0, 1'b0, 1'b0, "R4 upper band edge high");
        frame(3,        1, 1'b1, 1'b1, 1'b1, 1'b0, "R5 lower band edge high lock");

        // high-rate timeout, rate_high kept
        idle(THI - 2);
        push(1'b0, 1'b1, 1'b1, 1'b0, "R7 one clock before high timeout");
        idle(1);
        push(1'b0, 1'b0, 1'b1, 1'b1, "R7 high timeout, R8 rate kept");
        idle(3);

        // reset mid-run
        rst = 1'b1;
        idle(2);
        push(1'b0, 1'b0, 1'b0, 1'b0, "R1 reset clears all");
        idle(2);
        rst = 1'b0;
        idle(3);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule